// File: doc/BRIEF.md
# Timer Capture/Compare/PWM Channel

This block is a single channel of a general-purpose timer. It sits beside a shared free-running counter that lives elsewhere. From that counter it receives the current count, a step strobe that marks cycles where the count has advanced, the count direction, a rollover pulse and the timer-wide center-aligned select. The channel holds a control field and a channel value register. Depending on those, it timestamps edges on its pin, drives the pin on a compare match, or produces an edge-aligned or center-aligned PWM waveform of either polarity.

Every capture or match that counts as a channel event sets a sticky event flag. Software clears the flag by writing a one to it. A separate enable bit forwards the flag to the interrupt line. When the edge/level field is zero, the channel stops driving its pin, and the pin is then free for general-purpose use or as an external timer clock.

The control write/read layout is six bits: bit 5 is the event flag (write 1 to clear), bit 4 is the interrupt enable, bits 3:2 are the mode field and bits 1:0 are the edge/level field.

Top module: `tmr_chan`

## Requirements
- R1: After reset, the control readback, the value readback, pin_out, pin_oe and irq are all zero.
- R2: With edge/level 00 the pin output enable is 0 in every mode. With center select 0 and mode 01, a match still sets the flag (software compare).
- R3: With center select 0 and mode 00, edge/level 01, 10 and 11 capture on a rising edge, a falling edge or either edge of pin_in, after a two-flop synchronizer. The edge shows in the readback three clock edges after pin_in changes, and pin_oe is 0 while capturing.
- R4: A match is a step cycle where cnt_val equals the channel value. With center select 0 and mode 01, edge/level 01, 10 and 11 toggle, clear or set pin_out on a match, and the flag is set.
- R5: With center select 0 and mode bit 3 set, edge-aligned PWM runs. If edge/level bit 1 is set, a match drives pin_out to 0 and a rollover drives it to 1. Otherwise a match drives it to 1 and a rollover drives it to 0. If both happen in the same step, the match wins. A match sets the flag.
- R6: With center select 1, center-aligned PWM runs whatever the mode bits are. If edge/level bit 1 is set, a match while counting up drives pin_out to 0 and a match while counting down drives it to 1. If bit 1 is clear, the levels are swapped. No flag is set in this mode.
- R7: Writing control bit 5 as 1 clears the flag, and writing it as 0 leaves the flag unchanged. A flag-setting event in the same cycle as a clear wins.
- R8: irq is high exactly when the flag and the interrupt enable are both set.
- R9: A capture copies the cnt_val of the detection cycle into the value register in the same cycle that the flag is set. Software writes load that register, and a capture in the same cycle takes precedence.
- R10: With cnt_en low, an equal count is not a match: neither pin_out nor the flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_en | input | 1 | Counter step strobe |
| cnt_down | input | 1 | Counter is counting down |
| cnt_wrap | input | 1 | Counter rollover this step |
| center_sel | input | 1 | Timer-wide center-aligned select |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 6 | Control write data |
| val_wr | input | 1 | Value register write strobe |
| val_wdata | input | CNT_W | Value register write data |
| ctl_rd | output | 6 | Control readback including flag |
| val_rd | output | CNT_W | Channel value readback |
| pin_in | input | 1 | Pin input for capture |
| pin_out | output | 1 | Pin output level |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Channel interrupt |

## Verification
The bench builds the channel with the default 16-bit counter width and the two-stage synchronizer. With these values, the full compare path uses every bit, and the capture latency of three edges is a fixed, countable quantity. A vector table walks every compare action, both polarities of both PWM kinds and the released-pin codes. The checks carry the pin state from one vector to the next, so toggles and set/clear priority are observed in sequence. Directed tests cover each capture edge selection, edges that must be ignored, flag clearing and interrupt gating.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  localparam int CTL_W   = 6;
  localparam int CTL_CLR = 5;
  localparam int CTL_IE  = 4;

  typedef enum logic [1:0] {
    K_CAPTURE = 2'd0,
    K_COMPARE = 2'd1,
    K_EPWM    = 2'd2,
    K_CPWM    = 2'd3
  } chan_kind_e;

  function automatic chan_kind_e kind_of(input logic center, input logic [1:0] mode);
    if (center)              return K_CPWM;
    else if (mode[1])        return K_EPWM;
    else if (mode == 2'b01)  return K_COMPARE;
    else                     return K_CAPTURE;
  endfunction
endpackage

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [5:0]       ctl_wdata,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] val_wdata,
  input  logic             cap_evt,
  input  logic [CNT_W-1:0] cap_val,
  input  logic             set_evt,
  output logic             ie_q,
  output logic [1:0]       mode_q,
  output logic [1:0]       els_q,
  output logic             flag_q,
  output logic [CNT_W-1:0] val_q
);
  import tmr_chan_pkg::*;

  logic             ie_d, flag_d;
  logic [1:0]       mode_d, els_d;
  logic [CNT_W-1:0] val_d;

  always_comb begin
    ie_d   = ie_q;
    mode_d = mode_q;
    els_d  = els_q;
    flag_d = flag_q;
    val_d  = val_q;
    if (ctl_wr) begin
      ie_d   = ctl_wdata[CTL_IE];
      mode_d = ctl_wdata[3:2];
      els_d  = ctl_wdata[1:0];
      if (ctl_wdata[CTL_CLR]) flag_d = 1'b0;
    end
    if (set_evt) flag_d = 1'b1;
    if (val_wr)  val_d  = val_wdata;
    if (cap_evt) val_d  = cap_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      mode_q <= 2'b00;
      els_q  <= 2'b00;
      flag_q <= 1'b0;
      val_q  <= '0;
    end else begin
      ie_q   <= ie_d;
      mode_q <= mode_d;
      els_q  <= els_d;
      flag_q <= flag_d;
      val_q  <= val_d;
    end
  end
endmodule

// File: rtl/tmr_chan_capture.sv
module tmr_chan_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic       active,
  input  logic [1:0] els,
  output logic       cap_evt
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   rise, fall, synced;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign sync_d = pin_in;
    end else begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], pin_in};
    end
  endgenerate

  assign synced = sync_q[SYNC_STAGES-1];
  assign prev_d = synced;
  assign rise   = synced & ~prev_q;
  assign fall   = ~synced & prev_q;

  always_comb begin
    cap_evt = 1'b0;
    if (active) begin
      case (els)
        2'b01:   cap_evt = rise;
        2'b10:   cap_evt = fall;
        2'b11:   cap_evt = rise | fall;
        default: cap_evt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/tmr_chan_pinlogic.sv
module tmr_chan_pinlogic (
  input  logic                     clk,
  input  logic                     rst_n,
  input  tmr_chan_pkg::chan_kind_e kind,
  input  logic [1:0]               els,
  input  logic                     match,
  input  logic                     step,
  input  logic                     wrap,
  input  logic                     down,
  output logic                     pin_q
);
  import tmr_chan_pkg::*;

  logic pin_d;
  logic high_true;

  assign high_true = els[1];

  always_comb begin
    pin_d = pin_q;
    if (els != 2'b00) begin
      case (kind)
        K_COMPARE: if (match) begin
          case (els)
            2'b01:   pin_d = ~pin_q;
            2'b10:   pin_d = 1'b0;
            default: pin_d = 1'b1;
          endcase
        end
        K_EPWM: begin
          if (match)             pin_d = ~high_true;
          else if (step && wrap) pin_d = high_true;
        end
        K_CPWM: if (match) begin
          pin_d = down ? high_true : ~high_true;
        end
        default: pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_en,
  input  logic             cnt_down,
  input  logic             cnt_wrap,
  input  logic             center_sel,
  input  logic             ctl_wr,
  input  logic [5:0]       ctl_wdata,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] val_wdata,
  output logic [5:0]       ctl_rd,
  output logic [CNT_W-1:0] val_rd,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             irq
);
  import tmr_chan_pkg::*;

  logic [1:0]       rst_pipe;
  logic             rst_sn;
  logic             ie_q, flag_q;
  logic [1:0]       mode_q, els_q;
  logic [CNT_W-1:0] val_q;
  logic             cap_evt, set_evt, match;
  chan_kind_e       kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  assign kind    = kind_of(center_sel, mode_q);
  assign match   = cnt_en && (cnt_val == val_q);
  assign set_evt = cap_evt || (match && (kind == K_COMPARE || kind == K_EPWM));

  tmr_chan_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_sn),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .val_wr(val_wr), .val_wdata(val_wdata),
    .cap_evt(cap_evt), .cap_val(cnt_val), .set_evt(set_evt),
    .ie_q(ie_q), .mode_q(mode_q), .els_q(els_q), .flag_q(flag_q), .val_q(val_q)
  );

  tmr_chan_capture #(.SYNC_STAGES(SYNC_STAGES)) cap_i (
    .clk(clk), .rst_n(rst_sn), .pin_in(pin_in),
    .active(kind == K_CAPTURE), .els(els_q), .cap_evt(cap_evt)
  );

  tmr_chan_pinlogic pin_i (
    .clk(clk), .rst_n(rst_sn), .kind(kind), .els(els_q),
    .match(match), .step(cnt_en), .wrap(cnt_wrap), .down(cnt_down),
    .pin_q(pin_out)
  );

  assign pin_oe = (els_q != 2'b00) && (kind != K_CAPTURE);
  assign irq    = flag_q & ie_q;
  assign ctl_rd = {flag_q, ie_q, mode_q, els_q};
  assign val_rd = val_q;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             center_sel,
  input logic [1:0]       mode_q,
  input logic [1:0]       els_q,
  input logic             ie_q,
  input logic             flag_q,
  input logic             match,
  input logic             cap_evt,
  input logic             set_evt,
  input logic             ctl_wr,
  input logic [5:0]       ctl_wdata,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] val_rd,
  input logic             pin_out,
  input logic             pin_oe,
  input logic             irq
);
  // R2
  released_pin_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (els_q == 2'b00) |-> !pin_oe);

  // R9
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    cap_evt |=> (val_rd == $past(cnt_val)) && flag_q);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctl_wr && ctl_wdata[5] && !set_evt) |=> !flag_q);

  // R10
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !set_evt |=> !$rose(flag_q));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    irq |-> ie_q);

  // R4
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!center_sel && mode_q == 2'b01 && els_q == 2'b01 && match) |=> (pin_out != $past(pin_out)));

  // R5
  epwm_high_true_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!center_sel && mode_q[1] && els_q[1] && match) |=> !pin_out);
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_sn(rst_sn), .center_sel(center_sel), .mode_q(mode_q),
  .els_q(els_q), .ie_q(ie_q), .flag_q(flag_q), .match(match),
  .cap_evt(cap_evt), .set_evt(set_evt), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .cnt_val(cnt_val), .val_rd(val_rd), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/tmr_chan_tb_top.sv
module tmr_chan_tb_top;
  localparam int W = 16;

  typedef struct packed {
    logic [5:0]   ctl;
    logic [W-1:0] chv;
    logic         ctr;
    logic         dn;
    logic         wr;
    logic [W-1:0] cnt;
    logic         e_pin;
    logic         e_oe;
    logic         e_flag;
  } vec_t;

  // ctl: [4] irq enable, [3:2] mode, [1:0] edge/level
  localparam vec_t VECS [16] = '{
    '{6'h17, 16'h0010, 1'b0, 1'b0, 1'b0, 16'h0010, 1'b1, 1'b1, 1'b1}, // R4 set
    '{6'h05, 16'h0020, 1'b0, 1'b0, 1'b0, 16'h0020, 1'b0, 1'b1, 1'b1}, // R4 toggle
    '{6'h05, 16'h0020, 1'b0, 1'b0, 1'b0, 16'h0020, 1'b1, 1'b1, 1'b1}, // R4 toggle
    '{6'h06, 16'h0030, 1'b0, 1'b0, 1'b0, 16'h0030, 1'b0, 1'b1, 1'b1}, // R4 clear
    '{6'h07, 16'h0030, 1'b0, 1'b0, 1'b0, 16'h0031, 1'b0, 1'b1, 1'b0}, // R4 no match
    '{6'h0A, 16'h0040, 1'b0, 1'b0, 1'b1, 16'h00FF, 1'b1, 1'b1, 1'b0}, // R5 ht wrap
    '{6'h1A, 16'h0040, 1'b0, 1'b0, 1'b0, 16'h0040, 1'b0, 1'b1, 1'b1}, // R5 ht match
    '{6'h0D, 16'h0040, 1'b0, 1'b0, 1'b1, 16'h00FF, 1'b0, 1'b1, 1'b0}, // R5 lt wrap
    '{6'h0D, 16'h0040, 1'b0, 1'b0, 1'b0, 16'h0040, 1'b1, 1'b1, 1'b1}, // R5 lt match
    '{6'h0A, 16'h00FF, 1'b0, 1'b0, 1'b1, 16'h00FF, 1'b0, 1'b1, 1'b1}, // R5 match beats wrap
    '{6'h02, 16'h0050, 1'b1, 1'b1, 1'b0, 16'h0050, 1'b1, 1'b1, 1'b0}, // R6 ht down
    '{6'h02, 16'h0050, 1'b1, 1'b0, 1'b0, 16'h0050, 1'b0, 1'b1, 1'b0}, // R6 ht up
    '{6'h01, 16'h0050, 1'b1, 1'b0, 1'b0, 16'h0050, 1'b1, 1'b1, 1'b0}, // R6 lt up
    '{6'h01, 16'h0050, 1'b1, 1'b1, 1'b0, 16'h0050, 1'b0, 1'b1, 1'b0}, // R6 lt down
    '{6'h04, 16'h0060, 1'b0, 1'b0, 1'b0, 16'h0060, 1'b0, 1'b0, 1'b1}, // R2 sw compare
    '{6'h00, 16'h0060, 1'b1, 1'b0, 1'b0, 16'h0060, 1'b0, 1'b0, 1'b0}  // R2 released
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] cnt_val;
  logic         cnt_en, cnt_down, cnt_wrap, center_sel;
  logic         ctl_wr, val_wr, pin_in;
  logic [5:0]   ctl_wdata;
  logic [W-1:0] val_wdata;
  logic [5:0]   ctl_rd;
  logic [W-1:0] val_rd;
  logic         pin_out, pin_oe, irq;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_chan #(.CNT_W(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_en(cnt_en),
    .cnt_down(cnt_down), .cnt_wrap(cnt_wrap), .center_sel(center_sel),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .val_wr(val_wr), .val_wdata(val_wdata),
    .ctl_rd(ctl_rd), .val_rd(val_rd), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [5:0] d);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cnt_val = '0; cnt_en = 1'b0; cnt_down = 1'b0; cnt_wrap = 1'b0;
    center_sel = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; val_wr = 1'b0;
    val_wdata = '0; pin_in = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    chk("R1 ctl", {26'd0, ctl_rd}, 32'd0);
    chk("R1 val", {16'd0, val_rd}, 32'd0);
    chk("R1 pins", {29'd0, pin_out, pin_oe, irq}, 32'd0);

    // table walk
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ctl_wr = 1'b1; ctl_wdata = {1'b1, VECS[i].ctl[4:0]};
      val_wr = 1'b1; val_wdata = VECS[i].chv;
      center_sel = VECS[i].ctr;
      @(negedge clk);
      ctl_wr = 1'b0; val_wr = 1'b0;
      cnt_en = 1'b1; cnt_val = VECS[i].cnt; cnt_down = VECS[i].dn; cnt_wrap = VECS[i].wr;
      @(negedge clk);
      cnt_en = 1'b0; cnt_wrap = 1'b0;
      chk($sformatf("R4/R5/R6 vec%0d pin", i), {31'd0, pin_out}, {31'd0, VECS[i].e_pin});
      chk($sformatf("R2 vec%0d oe", i), {31'd0, pin_oe}, {31'd0, VECS[i].e_oe});
      chk($sformatf("R7 vec%0d flag", i), {31'd0, ctl_rd[5]}, {31'd0, VECS[i].e_flag});
      chk($sformatf("R8 vec%0d irq", i), {31'd0, irq}, {31'd0, VECS[i].e_flag & VECS[i].ctl[4]});
    end
    center_sel = 1'b0;

    // R10 equal count without a step is no match
    wr_ctl(6'h27);
    cnt_val = 16'h0060; idle(2);
    chk("R10 flag", {31'd0, ctl_rd[5]}, 32'd0);
    chk("R10 pin", {31'd0, pin_out}, 32'd0);

    // R9 software value write
    @(negedge clk); val_wr = 1'b1; val_wdata = 16'hBEEF;
    @(negedge clk); val_wr = 1'b0;
    chk("R9 write", {16'd0, val_rd}, 32'h0000BEEF);

    // R3 rising capture
    wr_ctl(6'h21);
    cnt_val = 16'h1234;
    chk("R3 oe capture", {31'd0, pin_oe}, 32'd0);
    pin_in = 1'b1;
    idle(2);
    chk("R3 latency", {31'd0, ctl_rd[5]}, 32'd0);
    idle(1);
    chk("R3 rise flag", {31'd0, ctl_rd[5]}, 32'd1);
    chk("R9 rise value", {16'd0, val_rd}, 32'h00001234);

    // R7 write 0 to flag keeps it, write 1 clears
    wr_ctl(6'h01);
    chk("R7 keep", {31'd0, ctl_rd[5]}, 32'd1);
    wr_ctl(6'h21);
    chk("R7 clear", {31'd0, ctl_rd[5]}, 32'd0);

    // R3 falling edge ignored with rising select
    cnt_val = 16'h5555; pin_in = 1'b0; idle(4);
    chk("R3 fall ignored flag", {31'd0, ctl_rd[5]}, 32'd0);
    chk("R3 fall ignored value", {16'd0, val_rd}, 32'h00001234);

    // R3 falling select
    wr_ctl(6'h22);
    cnt_val = 16'h2222; pin_in = 1'b1; idle(4);
    chk("R3 rise ignored", {31'd0, ctl_rd[5]}, 32'd0);
    pin_in = 1'b0; idle(3);
    chk("R3 fall flag", {31'd0, ctl_rd[5]}, 32'd1);
    chk("R9 fall value", {16'd0, val_rd}, 32'h00002222);

    // R3 both edges, R8 irq enable
    wr_ctl(6'h33);
    cnt_val = 16'h3333; pin_in = 1'b1; idle(3);
    chk("R3 both rise", {16'd0, val_rd}, 32'h00003333);
    chk("R8 irq on", {31'd0, irq}, 32'd1);
    wr_ctl(6'h23);
    cnt_val = 16'h4444; pin_in = 1'b0; idle(3);
    chk("R3 both fall", {16'd0, val_rd}, 32'h00004444);
    chk("R8 irq off", {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule